// File: doc/BRIEF.md
# Dual-Issue Instruction Pairing Checker

This block decides, once per cycle, how many of the two oldest instructions in an in-order issue queue may go to execution together. Each slot presents a class code produced by an earlier decode step, a flag that marks 64-bit operands, and a valid bit. The younger slot also carries a flag that says it reads a register the older slot writes. The block applies a fixed set of structural pairing rules and returns an issue count (0, 1 or 2) and a functional-unit select for each slot.

The decision is computed combinationally from the current inputs and is held in output registers. It appears on the outputs one clock after the inputs are sampled. The queue that feeds the block pops as many entries as the registered count reports. All pins are plain control signals with no handshake. The younger slot never issues unless the older one issues in the same cycle, so program order is kept.

Top module: `pair_issue`

## Requirements
- R1: While `rst_n` is low, `issue_cnt`, `s0_unit` and `s1_unit` are all 0. After reset, the outputs show the decision for the inputs sampled at the previous rising clock edge.
- R2: The class codes are ALU basic=0, ALU advanced=1, load/store=2, multiply=3, divide=4, floating point=5, user extension=6, branch=7, DSP ALU=8 and DSP multiply=9. Codes 10–15 are treated as user extension. When `s0_vld` is 0, the issue count is 0.
- R3: The unit codes are none=0, ALU A=1, ALU B=2, load/store=3, multiplier=4, divider=5, FPU=6, extension=7 and branch=8. When only slot 0 is valid, the count is 1 and `s0_unit` is the home unit of slot 0's class. All ALU-type classes go to ALU A, and both multiply classes go to the multiplier.
- R4: Two basic ALU instructions pair. Slot 0 takes ALU A and slot 1 takes ALU B.
- R5: Apart from the exceptions in R4 and R9, two instructions pair only when their groups differ. The groups are: ALU (basic, advanced, DSP ALU), load/store, multiply (both kinds), divide, FPU, extension and branch. Because of this, the single multiplier, divider and FPU never receive two instructions in one cycle.
- R6: A DSP multiply pairs with a load/store, in either slot order.
- R7: A DSP multiply never pairs with a divide, floating-point, user-extension or branch instruction, in either slot order.
- R8: An advanced ALU or DSP ALU instruction with its 64-bit flag set issues alone, whichever slot it occupies. The 64-bit flag has no effect on other classes.
- R9: Two DSP ALU instructions that both have the 64-bit flag clear pair, on ALU A and ALU B.
- R10: When `s1_dep` is set, only slot 0 issues.
- R11: `s1_unit` is 0 whenever the count is not 2. The two units are distinct whenever the count is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s0_vld | input | 1 | Slot 0 (older) holds an instruction |
| s0_cls | input | 4 | Slot 0 class code |
| s0_wide | input | 1 | Slot 0 uses 64-bit operands |
| s1_vld | input | 1 | Slot 1 (younger) holds an instruction |
| s1_cls | input | 4 | Slot 1 class code |
| s1_wide | input | 1 | Slot 1 uses 64-bit operands |
| s1_dep | input | 1 | Slot 1 reads a register that slot 0 writes |
| issue_cnt | output | 2 | Registered number of instructions issued |
| s0_unit | output | 4 | Registered unit select for slot 0 |
| s1_unit | output | 4 | Registered unit select for slot 1 |

## Verification
The bench uses the package defaults: 4-bit class and unit fields and a 2-bit count. These widths cover all ten defined classes and also the undefined class codes, which must fall back to the extension unit. The stimulus walks through pairs of same-group and cross-group classes, including the DSP multiply exclusions in both slot orders. It also sets the 64-bit flag on classes where it matters and on classes where it does not. Cases with the dependency flag set and cases with slot 0 invalid probe the in-order guarantee against the one-cycle output latency.

// File: rtl/pair_pkg.sv
package pair_pkg;
  localparam int CLS_W  = 4;
  localparam int UNIT_W = 4;
  localparam int CNT_W  = 2;
  localparam int NSLOT  = 2;
  localparam int GRP_W  = 3;

  typedef enum logic [CLS_W-1:0] {
    CL_ALU  = 4'd0, CL_ALUX = 4'd1, CL_LDST = 4'd2, CL_MUL  = 4'd3,
    CL_DIV  = 4'd4, CL_FPU  = 4'd5, CL_USER = 4'd6, CL_BR   = 4'd7,
    CL_DALU = 4'd8, CL_DMUL = 4'd9
  } cls_e;

  typedef enum logic [UNIT_W-1:0] {
    U_NONE = 4'd0, U_ALU_A = 4'd1, U_ALU_B = 4'd2, U_LSU = 4'd3,
    U_MUL  = 4'd4, U_DIV   = 4'd5, U_FPU   = 4'd6, U_EXT = 4'd7,
    U_BRU  = 4'd8
  } unit_e;

  typedef enum logic [GRP_W-1:0] {
    G_ALU = 3'd0, G_LS = 3'd1, G_MUL = 3'd2, G_DIV = 3'd3,
    G_FP  = 3'd4, G_EXT = 3'd5, G_BR = 3'd6
  } grp_e;

  typedef struct packed {
    grp_e  grp;
    unit_e unit;
    logic  solo;      // wide advanced/DSP ALU op: must issue alone
    logic  basic;     // basic ALU op
    logic  dalu;      // DSP ALU op
    logic  dmul;      // DSP multiply
    logic  dmul_bar;  // class that may not sit beside a DSP multiply
  } cinfo_t;
endpackage

// File: rtl/pair_class_map.sv
module pair_class_map
  import pair_pkg::*;
(
  input  logic [CLS_W-1:0] cls,
  input  logic             wide,
  output cinfo_t           info
);
  always_comb begin
    info = '{grp: G_EXT, unit: U_EXT, solo: 1'b0, basic: 1'b0,
             dalu: 1'b0, dmul: 1'b0, dmul_bar: 1'b1};
    case (cls)
      CL_ALU:  begin info.grp = G_ALU; info.unit = U_ALU_A; info.basic = 1'b1; info.dmul_bar = 1'b0; end
      CL_ALUX: begin info.grp = G_ALU; info.unit = U_ALU_A; info.solo = wide; info.dmul_bar = 1'b0; end
      CL_DALU: begin info.grp = G_ALU; info.unit = U_ALU_A; info.solo = wide; info.dalu = 1'b1; info.dmul_bar = 1'b0; end
      CL_LDST: begin info.grp = G_LS;  info.unit = U_LSU;  info.dmul_bar = 1'b0; end
      CL_MUL:  begin info.grp = G_MUL; info.unit = U_MUL;  info.dmul_bar = 1'b0; end
      CL_DMUL: begin info.grp = G_MUL; info.unit = U_MUL;  info.dmul = 1'b1; info.dmul_bar = 1'b0; end
      CL_DIV:  begin info.grp = G_DIV; info.unit = U_DIV; end
      CL_FPU:  begin info.grp = G_FP;  info.unit = U_FPU; end
      CL_BR:   begin info.grp = G_BR;  info.unit = U_BRU; end
      default: ; // user extension and undefined codes
    endcase
  end
endmodule

// File: rtl/pair_rules.sv
module pair_rules
  import pair_pkg::*;
(
  input  cinfo_t           i0,
  input  cinfo_t           i1,
  input  logic             v0,
  input  logic             v1,
  input  logic             dep,
  output logic [CNT_W-1:0] cnt,
  output unit_e            u0,
  output unit_e            u1
);
  logic same_grp, alu_twin, dmul_clash, may_pair;

  always_comb begin
    same_grp   = (i0.grp == i1.grp);
    alu_twin   = (i0.basic & i1.basic) | (i0.dalu & i1.dalu);
    dmul_clash = (i0.dmul & i1.dmul_bar) | (i1.dmul & i0.dmul_bar);
    may_pair   = ~i0.solo & ~i1.solo & ~dep & ~dmul_clash & (~same_grp | alu_twin);

    if (!v0)           cnt = CNT_W'(0);
    else if (!v1)      cnt = CNT_W'(1);
    else if (may_pair) cnt = CNT_W'(2);
    else               cnt = CNT_W'(1);

    u0 = v0 ? i0.unit : U_NONE;
    if (cnt != CNT_W'(2))                          u1 = U_NONE;
    else if (i0.grp == G_ALU && i1.grp == G_ALU)   u1 = U_ALU_B;
    else                                           u1 = i1.unit;
  end
endmodule

// File: rtl/pair_issue.sv
module pair_issue
  import pair_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s0_vld,
  input  logic [CLS_W-1:0]  s0_cls,
  input  logic              s0_wide,
  input  logic              s1_vld,
  input  logic [CLS_W-1:0]  s1_cls,
  input  logic              s1_wide,
  input  logic              s1_dep,
  output logic [CNT_W-1:0]  issue_cnt,
  output logic [UNIT_W-1:0] s0_unit,
  output logic [UNIT_W-1:0] s1_unit
);
  logic [NSLOT-1:0][CLS_W-1:0] cls_v;
  logic [NSLOT-1:0]            wide_v;
  cinfo_t                      info [NSLOT];
  logic [CNT_W-1:0]            cnt_d;
  unit_e                       u0_d, u1_d;

  assign cls_v  = {s1_cls, s0_cls};
  assign wide_v = {s1_wide, s0_wide};

  for (genvar g = 0; g < NSLOT; g++) begin : g_map
    pair_class_map u_map (
      .cls  (cls_v[g]),
      .wide (wide_v[g]),
      .info (info[g])
    );
  end

  pair_rules u_rules (
    .i0  (info[0]),
    .i1  (info[1]),
    .v0  (s0_vld),
    .v1  (s1_vld),
    .dep (s1_dep),
    .cnt (cnt_d),
    .u0  (u0_d),
    .u1  (u1_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      issue_cnt <= '0;
      s0_unit   <= '0;
      s1_unit   <= '0;
    end else begin
      issue_cnt <= cnt_d;
      s0_unit   <= u0_d;
      s1_unit   <= u1_d;
    end
  end
endmodule

// File: rtl/pair_chk.sv
module pair_chk
  import pair_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              s0_vld,
  input logic [CLS_W-1:0]  s0_cls,
  input logic              s0_wide,
  input logic              s1_vld,
  input logic [CLS_W-1:0]  s1_cls,
  input logic              s1_wide,
  input logic              s1_dep,
  input logic [CNT_W-1:0]  issue_cnt,
  input logic [UNIT_W-1:0] s0_unit,
  input logic [UNIT_W-1:0] s1_unit
);
  logic s0_solo, s1_solo;
  assign s0_solo = s0_vld & s0_wide & (s0_cls == CL_ALUX || s0_cls == CL_DALU);
  assign s1_solo = s1_vld & s1_wide & (s1_cls == CL_ALUX || s1_cls == CL_DALU);

  // R2
  no_issue_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(s0_vld) |-> issue_cnt == '0);

  // R3
  single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(s0_vld && !s1_vld) |-> issue_cnt <= CNT_W'(1));

  // R8
  wide_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(s0_solo || s1_solo) |-> issue_cnt != CNT_W'(2));

  // R10
  dep_serial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(s1_dep) |-> issue_cnt != CNT_W'(2));

  // R11
  in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_cnt != CNT_W'(2) |-> s1_unit == '0);

  // R11
  distinct_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_cnt == CNT_W'(2) |-> (s0_unit != s1_unit && s1_unit != '0));

  // R7
  dmul_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(s0_cls == CL_DMUL && (s1_cls == CL_DIV || s1_cls == CL_FPU || s1_cls == CL_BR))
      |-> issue_cnt != CNT_W'(2));
endmodule

bind pair_issue pair_chk u_chk (.*);

// File: tb/pair_issue_tb.sv
module pair_issue_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s0_vld = 0, s0_wide = 0, s1_vld = 0, s1_wide = 0, s1_dep = 0;
  logic [3:0] s0_cls = 0, s1_cls = 0;
  logic [1:0] issue_cnt;
  logic [3:0] s0_unit, s1_unit;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    int    cnt;
    int    u0;
    int    u1;
    string req;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  pair_issue u_dut (
    .clk(clk), .rst_n(rst_n),
    .s0_vld(s0_vld), .s0_cls(s0_cls), .s0_wide(s0_wide),
    .s1_vld(s1_vld), .s1_cls(s1_cls), .s1_wide(s1_wide),
    .s1_dep(s1_dep),
    .issue_cnt(issue_cnt), .s0_unit(s0_unit), .s1_unit(s1_unit)
  );

  task automatic check(input string req, input int act, input int expv, input string what);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // driver: apply one pair on the falling edge, queue its expected result
  task automatic drive(input string req,
                       input bit v0, input int c0, input bit w0,
                       input bit v1, input int c1, input bit w1, input bit dep,
                       input int ecnt, input int eu0, input int eu1);
    exp_t e;
    @(negedge clk);
    s0_vld = v0; s0_cls = 4'(c0); s0_wide = w0;
    s1_vld = v1; s1_cls = 4'(c1); s1_wide = w1; s1_dep = dep;
    e.cnt = ecnt; e.u0 = eu0; e.u1 = eu1; e.req = req;
    sb.push_back(e);
  endtask

  // monitor: shortly after each rising edge the registered decision is visible
  always @(posedge clk) begin
    #1;
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.req, int'(issue_cnt), e.cnt, "issue_cnt");
      check(e.req, int'(s0_unit),   e.u0,  "s0_unit");
      check(e.req, int'(s1_unit),   e.u1,  "s1_unit");
    end
  end

  bit finished = 0;
  initial begin
    #40000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    s0_vld = 1; s0_cls = 0; s1_vld = 1; s1_cls = 0;
    repeat (3) @(negedge clk);
    // R1: outputs cleared under reset
    check("R1", int'(issue_cnt), 0, "issue_cnt in reset");
    check("R1", int'(s0_unit),   0, "s0_unit in reset");
    check("R1", int'(s1_unit),   0, "s1_unit in reset");
    s0_vld = 0; s1_vld = 0;
    rst_n = 1'b1;

    // classes: 0 ALU,1 ALUX,2 LDST,3 MUL,4 DIV,5 FPU,6 USER,7 BR,8 DALU,9 DMUL
    // units:   1 ALU_A,2 ALU_B,3 LSU,4 MUL,5 DIV,6 FPU,7 EXT,8 BRU
    drive("R2",  0,0,0, 1,2,0, 0,  0,0,0);
    drive("R3",  1,2,0, 0,0,0, 0,  1,3,0);
    drive("R3",  1,9,0, 0,0,0, 0,  1,4,0);
    drive("R4",  1,0,0, 1,0,0, 0,  2,1,2);
    drive("R5",  1,0,0, 1,2,0, 0,  2,1,3);
    drive("R5",  1,3,0, 1,3,0, 0,  1,4,0);
    drive("R5",  1,4,0, 1,4,0, 0,  1,5,0);
    drive("R5",  1,5,0, 1,2,0, 0,  2,6,3);
    drive("R5",  1,0,0, 1,8,0, 0,  1,1,0);
    drive("R5",  1,3,0, 1,9,0, 0,  1,4,0);
    drive("R6",  1,9,0, 1,2,0, 0,  2,4,3);
    drive("R6",  1,2,0, 1,9,0, 0,  2,3,4);
    drive("R7",  1,9,0, 1,4,0, 0,  1,4,0);
    drive("R7",  1,5,0, 1,9,0, 0,  1,6,0);
    drive("R7",  1,9,0, 1,6,0, 0,  1,4,0);
    drive("R7",  1,7,0, 1,9,0, 0,  1,8,0);
    drive("R8",  1,1,1, 1,2,0, 0,  1,1,0);
    drive("R8",  1,2,0, 1,8,1, 0,  1,3,0);
    drive("R8",  1,1,0, 1,2,0, 0,  2,1,3);
    drive("R8",  1,0,1, 1,0,1, 0,  2,1,2);
    drive("R9",  1,8,0, 1,8,0, 0,  2,1,2);
    drive("R9",  1,8,1, 1,8,0, 0,  1,1,0);
    drive("R10", 1,0,0, 1,2,0, 1,  1,1,0);
    drive("R11", 0,0,0, 1,0,0, 0,  0,0,0);
    drive("R2",  1,12,0, 1,2,0, 0, 2,7,3);
    @(negedge clk);
    s0_vld = 0; s1_vld = 0; s1_dep = 0;
    repeat (3) @(negedge clk);
    check("R1", sb.size(), 0, "pending results");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule